// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets logic running on a clock read and write an external asynchronous static RAM of 32K bytes. A host presents one request at a time: a 15-bit address, a read/write flag and, for writes, a data byte. It holds the request until it sees a one-cycle acknowledge. For reads, the returned byte is valid in the same cycle as the acknowledge.

On the memory side the block drives an active-low select, an active-low write strobe, an active-low output enable and an active-high enable. The shared data pins are split into an output value, an output enable and an input value. Every memory timing minimum is given in nanoseconds and converted at elaboration into a count of clock cycles. The conversion rounds up and never gives fewer than one cycle.

Writes are timed by the write strobe, and reads are timed by address and output enable. Before the block drives the data pins after a read, it waits out the memory's output-release time. Between two writes it always returns the write strobe high for a recovery period.

Top module: `asram_bridge`

## Requirements
- R1: While reset is asserted, and afterwards until the first request, the select and write strobe and output enable are high (inactive), the enable is low, the data pins are not driven and the acknowledge is low.
- R2: In every cycle in which the select is high (no access in progress), the enable is low, the write strobe and output enable are high and the data pins are not driven.
- R3: A read holds the select low, the enable high, the write strobe high, the output enable low and the data pins undriven for exactly ceil(T_AA_NS/CLK_NS) cycles (minimum 1), with the address constant.
- R4: The read result is the byte the memory presents during the last of those cycles. The acknowledge rises in the cycle right after the output enable returns high, and the result is valid in that cycle.
- R5: A write holds the write strobe low for max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles. During that time the select is low, the enable is high and the data pins are driven, and the address and data are constant.
- R6: After the write strobe rises, the select stays low, the data stays driven and the address stays constant for ceil(T_WR_NS/CLK_NS) cycles with the strobe high. The write acknowledge comes in the cycle right after that period.
- R7: A write that follows a read begins with exactly ceil(T_OZ_NS/CLK_NS) cycles of select low, output enable high, write strobe high and data pins undriven, immediately before the write strobe falls.
- R8: A write that follows a write, or the first access after reset, has no turnaround: the write strobe falls in the first cycle the select is low.
- R9: The data pins are never driven in a cycle in which the output enable is low.
- R10: Each request receives exactly one acknowledge, and that acknowledge lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with the acknowledge of a read |
| mem_addr | output | 15 | Memory address |
| mem_ce | output | 1 | Memory enable, active high |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | 1 = controller drives the data pins |
| mem_dq_in | input | 8 | Value sampled from the data pins |

## Verification
The bench runs the block at a 20 ns clock with T_AA_NS=45, T_WP_NS=30, T_DS_NS=41, T_WR_NS=21 and T_OZ_NS=25. These values give a 3-cycle read window, a 2-cycle recovery and a 2-cycle turnaround, so an off-by-one in any counter shows up. Because 45/20 and 41/20 are not whole numbers, the ceiling rounding is exercised. The data-setup time is made longer than the strobe width, so the 3-cycle write pulse can come only from the larger of the two. The bench's memory model presents valid data only in the last cycle of the read window, so a capture one cycle early returns a wrong byte.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_DONE,
    ST_TURN,
    ST_WR_PULSE,
    ST_WR_RECOV
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock periods, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
`timescale 1ns/1ps
module asram_wait_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R3: a running window shrinks by exactly one per cycle until it expires
  assert_window_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int AA_C = 3,
  parameter int WP_C = 2,
  parameter int WR_C = 1,
  parameter int OZ_C = 2,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          wait_done,
  output logic          lat_en,
  output logic          cap_en,
  output logic          ctr_load,
  output logic [CW-1:0] ctr_val,
  output logic          ack,
  output logic          cs_n,
  output logic          ce,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  seq_state_e st_q, st_d;
  logic prev_rd_q, prev_rd_d;
  logic ack_q, ack_d;
  logic cs_n_q, cs_n_d;
  logic ce_q, ce_d;
  logic we_n_q, we_n_d;
  logic oe_n_q, oe_n_d;
  logic dq_oe_q, dq_oe_d;

  // next-state and control decode
  always_comb begin
    st_d     = st_q;
    lat_en   = 1'b0;
    cap_en   = 1'b0;
    ctr_load = 1'b0;
    ctr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && !ack_q) begin
          lat_en   = 1'b1;
          ctr_load = 1'b1;
          if (!req_write) begin
            st_d    = ST_RD_WAIT;
            ctr_val = CW'(AA_C - 1);
          end else if (prev_rd_q) begin
            st_d    = ST_TURN;
            ctr_val = CW'(OZ_C - 1);
          end else begin
            st_d    = ST_WR_PULSE;
            ctr_val = CW'(WP_C - 1);
          end
        end
      end
      ST_RD_WAIT: begin
        if (wait_done) begin
          st_d   = ST_RD_DONE;
          cap_en = 1'b1;
        end
      end
      ST_RD_DONE: begin
        st_d = ST_IDLE;
      end
      ST_TURN: begin
        if (wait_done) begin
          st_d     = ST_WR_PULSE;
          ctr_load = 1'b1;
          ctr_val  = CW'(WP_C - 1);
        end
      end
      ST_WR_PULSE: begin
        if (wait_done) begin
          st_d     = ST_WR_RECOV;
          ctr_load = 1'b1;
          ctr_val  = CW'(WR_C - 1);
        end
      end
      ST_WR_RECOV: begin
        if (wait_done) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // output decode from the upcoming state so pins come straight from flops
  always_comb begin
    cs_n_d  = (st_d == ST_IDLE);
    ce_d    = (st_d != ST_IDLE);
    oe_n_d  = (st_d != ST_RD_WAIT);
    we_n_d  = (st_d != ST_WR_PULSE);
    dq_oe_d = (st_d == ST_WR_PULSE) || (st_d == ST_WR_RECOV);
    ack_d   = (st_d == ST_RD_DONE) || ((st_q == ST_WR_RECOV) && wait_done);
    if (st_d == ST_RD_WAIT) begin
      prev_rd_d = 1'b1;
    end else if (st_d == ST_WR_PULSE) begin
      prev_rd_d = 1'b0;
    end else begin
      prev_rd_d = prev_rd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      prev_rd_q <= 1'b0;
      ack_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      ce_q      <= 1'b0;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      prev_rd_q <= prev_rd_d;
      ack_q     <= ack_d;
      cs_n_q    <= cs_n_d;
      ce_q      <= ce_d;
      we_n_q    <= we_n_d;
      oe_n_q    <= oe_n_d;
      dq_oe_q   <= dq_oe_d;
    end
  end

  assign ack   = ack_q;
  assign cs_n  = cs_n_q;
  assign ce    = ce_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;

  // checker: run length of output enable held high, saturating
  localparam int OZ_SAT = OZ_C + 2;
  localparam int TW     = $clog2(OZ_SAT + 1);
  logic [TW-1:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= TW'(OZ_SAT);
    end else if (!oe_n_q) begin
      oe_hi_cnt <= '0;
    end else if (oe_hi_cnt != TW'(OZ_SAT)) begin
      oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  // R7: drive starts only after memory release time plus the done/idle cycles
  assert_release_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_q) |-> (oe_hi_cnt >= TW'(OZ_SAT)));

  // R9: never fight the memory's output drivers
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> oe_n_q);

  // R5: a strobe low only with the part selected and data on the pins
  assert_strobe_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (!cs_n_q && ce_q && dq_oe_q));

  // R6: the strobe never falls again in the cycle after it rises
  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |=> we_n_q);

  // R10: acknowledge is a single-cycle pulse
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_en,
  input  logic          cap_en,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (lat_en) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wd_q;
  assign rsp_rdata  = rd_q;

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
module asram_bridge
  import asram_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 20,
  parameter int T_DS_NS = 15,
  parameter int T_WR_NS = 5,
  parameter int T_AA_NS = 25,
  parameter int T_OZ_NS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  // address-valid-to-strobe-end equals the strobe width because the address
  // is set in the cycle the strobe falls; data setup may stretch the pulse
  localparam int AA_C = ns_to_cycles(T_AA_NS, CLK_NS);
  localparam int WP_C = max2(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_DS_NS, CLK_NS));
  localparam int WR_C = ns_to_cycles(T_WR_NS, CLK_NS);
  localparam int OZ_C = ns_to_cycles(T_OZ_NS, CLK_NS);
  localparam int MAXC = max2(max2(AA_C, WP_C), max2(WR_C, OZ_C));
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  logic          lat_en;
  logic          cap_en;
  logic          ctr_load;
  logic [CW-1:0] ctr_val;
  logic          wait_done;

  asram_wait_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .expired  (wait_done)
  );

  asram_seq #(
    .AA_C (AA_C),
    .WP_C (WP_C),
    .WR_C (WR_C),
    .OZ_C (OZ_C),
    .CW   (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .wait_done (wait_done),
    .lat_en    (lat_en),
    .cap_en    (cap_en),
    .ctr_load  (ctr_load),
    .ctr_val   (ctr_val),
    .ack       (req_ack),
    .cs_n      (mem_cs_n),
    .ce        (mem_ce),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lat_en     (lat_en),
    .cap_en     (cap_en),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

  // R5: address and data do not move while the strobe is low
  assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R3: output enable low only in a fully qualified read
  assert_read_qualified_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_oe_n |-> (!mem_cs_n && mem_ce && mem_we_n && !mem_dq_oe));

  // R3: address held across consecutive read-window cycles
  assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_asram_bridge.sv
`timescale 1ns/1ps
module sim_asram_bridge;

  localparam int AW        = 15;
  localparam int DW        = 8;
  // expected cycle counts worked out by hand for the parameters below
  localparam int EXP_AA    = 3;  // ceil(45/20)
  localparam int EXP_PULSE = 3;  // max(ceil(30/20), ceil(41/20))
  localparam int EXP_WR    = 2;  // ceil(21/20)
  localparam int EXP_OZ    = 2;  // ceil(25/20)

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ack;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce;
  logic          mem_cs_n;
  logic          mem_we_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  asram_bridge #(
    .AW(AW), .DW(DW), .CLK_NS(20), .T_WP_NS(30), .T_DS_NS(41),
    .T_WR_NS(21), .T_AA_NS(45), .T_OZ_NS(25)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce(mem_ce),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] fill(input logic [AW-1:0] a);
    return a[7:0] ^ a[14:7] ^ 8'h5A;
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  int         age = 0;
  logic [AW-1:0] rd_addr_l = '0;
  logic [7:0] dq_in_r = 8'hEE;

  assign mem_dq_in = dq_in_r;

  always @(posedge mem_we_n) begin
    if (!mem_cs_n && mem_ce) mem[int'(mem_addr)] = mem_dq_out;
  end

  // data becomes valid only after EXP_AA cycles of a stable, qualified read
  always @(negedge clk) begin
    if (!mem_cs_n && mem_ce && mem_we_n && !mem_oe_n) begin
      if (age == 0 || mem_addr != rd_addr_l) age = 1;
      else age = age + 1;
      rd_addr_l = mem_addr;
    end else begin
      age = 0;
    end
    if (age >= EXP_AA)
      dq_in_r = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : fill(mem_addr);
    else
      dq_in_r = 8'hEE;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit         rd;
    logic [7:0] d;
  } exp_t;
  exp_t exp_q[$];

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    e.rd = !wr;
    e.d  = wr ? d : (shadow.exists(int'(a)) ? shadow[int'(a)] : fill(a));
    if (wr) shadow[int'(a)] = d;
    exp_q.push_back(e);
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    req_wdata = ~d;
  endtask

  // ---------------- monitor ----------------
  bit prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_ack = 1'b0;
  bit last_rd = 1'b0, in_rec = 1'b0;
  int low_run = 0, rec_run = 0, pre_run = 0, oe_run = 0;
  logic [AW-1:0] p_addr;
  logic [7:0]    p_data;

  always @(negedge clk) begin
    if (mon_en) begin
      bit rec_closed;
      rec_closed = 1'b0;
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R9 drive while output enabled", 1, 0);
      if (mem_cs_n)
        chk(!mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R2 idle levels",
            {mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
      // write strobe
      if (!mem_we_n) begin
        if (prev_we_n) begin
          if (last_rd) chk(pre_run == EXP_OZ, "R7 turnaround length", pre_run, EXP_OZ);
          else         chk(pre_run == 0, "R8 no turnaround", pre_run, 0);
          chk(!mem_cs_n && mem_ce && mem_dq_oe, "R5 strobe qualifiers",
              {mem_cs_n, mem_ce, mem_dq_oe}, 3'b011);
          low_run = 1;
          p_addr  = mem_addr;
          p_data  = mem_dq_out;
          last_rd = 1'b0;
        end else begin
          low_run++;
          chk(mem_addr == p_addr && mem_dq_out == p_data, "R5 stable during pulse",
              {mem_addr, mem_dq_out}, {p_addr, p_data});
        end
      end else if (!prev_we_n) begin
        chk(low_run == EXP_PULSE, "R5 pulse width", low_run, EXP_PULSE);
        in_rec  = 1'b1;
        rec_run = 0;
      end
      if (in_rec && mem_we_n) begin
        if (!mem_cs_n && mem_dq_oe) begin
          rec_run++;
          chk(mem_addr == p_addr && mem_dq_out == p_data, "R6 hold during recovery",
              {mem_addr, mem_dq_out}, {p_addr, p_data});
        end else begin
          chk(rec_run == EXP_WR, "R6 recovery length", rec_run, EXP_WR);
          in_rec     = 1'b0;
          rec_closed = 1'b1;
        end
      end
      // read window
      if (!mem_oe_n) begin
        if (prev_oe_n)
          chk(!mem_cs_n && mem_ce && mem_we_n && !mem_dq_oe, "R3 read qualifiers",
              {mem_cs_n, mem_ce, mem_we_n, mem_dq_oe}, 4'b0110);
        oe_run++;
        last_rd = 1'b1;
      end else if (!prev_oe_n) begin
        chk(oe_run == EXP_AA, "R3 read window length", oe_run, EXP_AA);
        oe_run = 0;
      end
      // acknowledge
      if (req_ack) begin
        chk(!prev_ack, "R10 ack single cycle", prev_ack, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected ack", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.rd) begin
            chk(rsp_rdata == e.d, "R4 read data", rsp_rdata, e.d);
            chk(!prev_oe_n && mem_oe_n, "R4 ack timing", prev_oe_n, 0);
          end else begin
            chk(rec_closed, "R6 write ack after recovery", rec_closed, 1);
          end
        end
      end
      pre_run   = (!mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe) ? pre_run + 1 : 0;
      prev_we_n = mem_we_n;
      prev_oe_n = mem_oe_n;
      prev_ack  = req_ack;
    end
  end

  task automatic check_quiet(input string tag);
    chk(mem_cs_n == 1'b1, tag, mem_cs_n, 1);
    chk(mem_ce == 1'b0, tag, mem_ce, 0);
    chk(mem_we_n == 1'b1 && mem_oe_n == 1'b1, tag, {mem_we_n, mem_oe_n}, 2'b11);
    chk(mem_dq_oe == 1'b0, tag, mem_dq_oe, 0);
    chk(req_ack == 1'b0, tag, req_ack, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    check_quiet("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1 after release");
    mon_en = 1'b1;

    op(1'b1, 15'h0001, 8'hA5);   // first access after reset: R8
    op(1'b1, 15'h7FFF, 8'h3C);   // write after write: R8
    op(1'b0, 15'h0001, 8'h00);   // R3 R4
    op(1'b0, 15'h7FFF, 8'h00);
    op(1'b0, 15'h1234, 8'h00);   // never written
    op(1'b1, 15'h1234, 8'h81);   // write after read: R7
    op(1'b0, 15'h1234, 8'h00);
    op(1'b1, 15'h0000, 8'hFF);   // R7 again
    op(1'b1, 15'h4000, 8'h00);   // R8
    op(1'b0, 15'h0000, 8'h00);
    op(1'b0, 15'h4000, 8'h00);
    for (int i = 1; i <= 10; i++) begin
      op((i % 3) != 0, AW'(i * 16'h0911), 8'(i * 37));
    end
    for (int i = 1; i <= 10; i++) begin
      op(1'b0, AW'(i * 16'h0911), 8'h00);
    end

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R10 every request acknowledged", exp_q.size(), 0);
    chk(mem_cs_n && !mem_ce && !mem_dq_oe, "R2 quiet after traffic",
        {mem_cs_n, mem_ce, mem_dq_oe}, 3'b100);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 actual=no-ack expected=ack");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule